// File: doc/BRIEF.md
# Edge-Triggered Interrupt Latch Controller

This block watches eight digital inputs and raises one shared interrupt when a chosen edge occurs on any of them. Two byte-wide masks select, for each channel, whether a rising edge, a falling edge or both are captured. Each capture is held in its own sticky flag, one for rising and one for falling per channel, until software clears it. The interrupt output is the OR of all sixteen flags.

Software uses a small synchronous register bus with a 4-bit offset, read and write strobes, and 8-bit data in each direction. A read of a per-channel offset returns that channel's flags and clears them. A write to the pulse offset drives the interrupt output low for a fixed number of cycles. Several such blocks can therefore share one edge-sensitive interrupt line: if flags are still pending after service, the line returns high and the receiver sees a fresh edge.

Top module: `edge_irq_latch`

## Requirements
- R1: After reset both enable masks, all rising and falling flags and `irq` are 0.
- R2: A 0-to-1 change on `din[n]` with bit n of the rising mask (offset 8) set makes rising flag n read 1 at offset 0xB (bit n). The flag is visible from the third rising clock edge after the input changes.
- R3: A 1-to-0 change on `din[n]` with bit n of the falling mask (offset 9) set makes falling flag n read 1 at offset 0xC (bit n), with the same latency.
- R4: An edge whose mask bit is 0 sets no flag. Clearing a mask bit leaves an already set flag set. Both masks read back what was written.
- R5: A read at offset n (0 to 7) returns {6'b0, falling flag n, rising flag n} and clears both flags of channel n only.
- R6: A read at offset 0xD returns the synchronized input value, two clock edges after `din` changes.
- R7: `irq` is 1 while any flag is set and no force pulse is active. It stays 1 until every flag has been cleared.
- R8: A write to offset 0xA holds `irq` low for exactly PULSE_CYCLES cycles after the write edge, and then `irq` follows the flags again. A further write during the pulse restarts the count. A read at 0xA returns `irq` in bit 0.
- R9: If an edge and a clearing read for the same channel fall on the same clock edge, the flag set by that edge stays set.
- R10: Offsets 0xE and 0xF read as 0. Writes to any offset other than 8, 9 and 0xA change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register offset |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle `rd` is high |
| din | input | 8 | Raw asynchronous inputs |
| irq | output | 1 | Shared interrupt output |

## Verification
The hardest case to reach is a clearing read that lands on the same clock edge on which a new edge of that channel is captured. The bench sets both flags of one channel first, then toggles its input and raises the read strobe exactly two edges after the change, when the synchronizer presents the edge. After that single edge the rising flag must read 1 and the falling flag 0. The restart of the force-low pulse is reached the same way, with a second write placed a few cycles into the first pulse and the low time counted from the second write.

// File: rtl/edge_irq_latch.sv
module edge_irq_latch #(
  parameter int PULSE_CYCLES = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] din,
  output logic       irq
);

  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] PULSE_LOAD = CW'(PULSE_CYCLES);

  localparam logic [3:0] OFS_REN   = 4'h8;
  localparam logic [3:0] OFS_FEN   = 4'h9;
  localparam logic [3:0] OFS_PULSE = 4'hA;
  localparam logic [3:0] OFS_RSTAT = 4'hB;
  localparam logic [3:0] OFS_FSTAT = 4'hC;
  localparam logic [3:0] OFS_INPUT = 4'hD;

  logic [7:0] sync1, sync2, sync3;
  logic [7:0] ren_q, fen_q;
  logic [7:0] rise_q, fall_q;
  logic [7:0] rise_ev, fall_ev;
  logic [7:0] clr_vec;
  logic [CW-1:0] pulse_cnt;
  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= din;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign rise_ev = sync2 & ~sync3;
  assign fall_ev = ~sync2 & sync3;
  assign clr_vec = (rd && !addr[3]) ? (8'd1 << addr[2:0]) : 8'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ren_q <= '0;
      fen_q <= '0;
    end else if (wr) begin
      if (addr == OFS_REN) ren_q <= wdata;
      if (addr == OFS_FEN) fen_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= (rise_q & ~clr_vec) | (rise_ev & ren_q);
      fall_q <= (fall_q & ~clr_vec) | (fall_ev & fen_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pulse_cnt <= '0;
    else if (wr && addr == OFS_PULSE)
      pulse_cnt <= PULSE_LOAD;
    else if (pulse_cnt != '0)
      pulse_cnt <= pulse_cnt - 1'b1;
  end

  assign pending = |{rise_q, fall_q};
  assign irq     = pending && (pulse_cnt == '0);

  always_comb begin
    rdata = 8'h00;
    if (rd) begin
      if (!addr[3]) begin
        rdata = {6'b0, fall_q[addr[2:0]], rise_q[addr[2:0]]};
      end else begin
        case (addr)
          OFS_REN:   rdata = ren_q;
          OFS_FEN:   rdata = fen_q;
          OFS_PULSE: rdata = {7'b0, irq};
          OFS_RSTAT: rdata = rise_q;
          OFS_FSTAT: rdata = fall_q;
          OFS_INPUT: rdata = sync2;
          default:   rdata = 8'h00;
        endcase
      end
    end
  end

  AST_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_q & $past(rise_q & ~clr_vec)) == $past(rise_q & ~clr_vec))); // R4
  AST_FALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fall_q & $past(fall_q & ~clr_vec)) == $past(fall_q & ~clr_vec))); // R4
  AST_RISE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_q & ~$past(rise_q) & ~$past(ren_q)) == 8'd0)); // R2
  AST_FALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fall_q & ~$past(fall_q) & ~$past(fen_q)) == 8'd0)); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !addr[3] && !rise_ev[addr[2:0]] && !fall_ev[addr[2:0]])
      |=> (!rise_q[$past(addr[2:0])] && !fall_q[$past(addr[2:0])])); // R5
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_PULSE) |=> !irq); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_q == 8'd0 && fall_q == 8'd0) |-> !irq); // R7

endmodule

// File: tb/test_edge_irq_latch.sv
module test_edge_irq_latch;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0, din = '0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_latch #(.PULSE_CYCLES(PULSE)) i_edge_irq_latch (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .din(din), .irq(irq));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic set_din(input logic [7:0] v);
    @(negedge clk); din = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_rd(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    reg_rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    expect_rd("R1 rising mask", 4'h8, 8'h00);
    expect_rd("R1 falling mask", 4'h9, 8'h00);
    expect_rd("R1 rising flags", 4'hB, 8'h00);
    expect_rd("R1 falling flags", 4'hC, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_rise;
    reg_wr(4'h8, 8'h01);
    expect_rd("R4 mask readback", 4'h8, 8'h01);
    set_din(8'h01);
    expect_rd("R2 rising flag", 4'hB, 8'h01);
    expect_rd("R3 no falling flag", 4'hC, 8'h00);
    check("R7 irq set", {7'b0, irq}, 8'h01);
    expect_rd("R6 input value", 4'hD, 8'h01);
    expect_rd("R5 read ch0", 4'h0, 8'h01);
    expect_rd("R5 cleared", 4'hB, 8'h00);
    check("R7 irq clear", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_fall;
    reg_wr(4'h8, 8'h00);
    reg_wr(4'h9, 8'h04);
    set_din(8'h05);
    expect_rd("R4 disabled rise", 4'hB, 8'h00);
    expect_rd("R4 no fall yet", 4'hC, 8'h00);
    set_din(8'h01);
    expect_rd("R3 falling flag", 4'hC, 8'h04);
    expect_rd("R5 read ch2", 4'h2, 8'h02);
    expect_rd("R5 ch2 cleared", 4'hC, 8'h00);
  endtask

  task automatic t_select;
    reg_wr(4'h8, 8'hFF);
    reg_wr(4'h9, 8'hFF);
    set_din(8'h81);
    set_din(8'h80);
    expect_rd("R2 ch7 rise", 4'hB, 8'h80);
    expect_rd("R3 ch0 fall", 4'hC, 8'h01);
    expect_rd("R5 read ch7", 4'h7, 8'h01);
    expect_rd("R5 other kept", 4'hC, 8'h01);
    check("R7 irq still set", {7'b0, irq}, 8'h01);
    expect_rd("R5 read ch0", 4'h0, 8'h02);
    check("R7 all cleared", {7'b0, irq}, 8'h00);
    set_din(8'h82);
    reg_wr(4'h8, 8'h00);
    expect_rd("R4 mask clear keeps flag", 4'hB, 8'h02);
    expect_rd("R5 read ch1", 4'h1, 8'h01);
  endtask

  task automatic t_pulse;
    reg_wr(4'h8, 8'hFF);
    set_din(8'h83);
    check("R7 irq before pulse", {7'b0, irq}, 8'h01);
    reg_wr(4'hA, 8'h00);
    for (int i = 0; i < PULSE; i++) begin
      check("R8 low during pulse", {7'b0, irq}, 8'h00);
      @(negedge clk);
    end
    check("R8 high after pulse", {7'b0, irq}, 8'h01);
    expect_rd("R8 read irq", 4'hA, 8'h01);
    reg_wr(4'hA, 8'h00);
    for (int i = 0; i < 3; i++) begin
      check("R8 low first pulse", {7'b0, irq}, 8'h00);
      @(negedge clk);
    end
    reg_wr(4'hA, 8'h00);
    for (int i = 0; i < PULSE; i++) begin
      check("R8 low after restart", {7'b0, irq}, 8'h00);
      @(negedge clk);
    end
    check("R8 high after restart", {7'b0, irq}, 8'h01);
    expect_rd("R5 read ch0", 4'h0, 8'h01);
    check("R7 cleared", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_race;
    set_din(8'h93);
    set_din(8'h83);
    expect_rd("R9 setup rise", 4'hB, 8'h10);
    expect_rd("R9 setup fall", 4'hC, 8'h10);
    @(negedge clk); din = 8'h93;
    @(negedge clk);
    @(negedge clk); addr = 4'h4; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    expect_rd("R9 edge wins", 4'hB, 8'h10);
    expect_rd("R9 fall cleared", 4'hC, 8'h00);
  endtask

  task automatic t_unused;
    reg_wr(4'hE, 8'hFF);
    reg_wr(4'hB, 8'hFF);
    reg_wr(4'hC, 8'hFF);
    reg_wr(4'h3, 8'hFF);
    expect_rd("R10 read E", 4'hE, 8'h00);
    expect_rd("R10 read F", 4'hF, 8'h00);
    expect_rd("R10 flags kept", 4'hB, 8'h10);
    expect_rd("R10 fall kept", 4'hC, 8'h00);
    expect_rd("R10 mask kept", 4'h8, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rise();
    t_fall();
    t_select();
    t_pulse();
    t_race();
    t_unused();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule